// File: doc/BRIEF.md
# PFC Protection and Startup Sequencer

This block sits between a set of analog comparators and the switching timing controller of a boundary-mode power-factor stage. It takes the comparator flags as inputs. These cover the supply against its start and stop levels, the feedback pin against its over-voltage and shutdown levels, a second over-voltage sense pin, die temperature and a missing-line indication. From them it decides whether the power switch may be driven.

The block keeps one latched state per protection, each with its own entry and exit condition. The feedback over-voltage recovers by itself. The second over-voltage stays latched until the supply has been cycled. It also produces a stepped soft-start reference code and a loop-ownership indication. That indication moves from an internal proportional controller, through a timed blend, to the external compensator. Synchronised flags feed a registered enable. The enable drops in the very cycle that a synchronised fault becomes visible.

Top module: `pfc_start_supervisor`

## Requirements
- R1: After reset `sw_en_o` is 0, `ref_code_o` is 0, `loop_mode_o` is 0 (internal) and `low_power_o` is 0.
- R2: The block becomes powered when `vcc_start_i` is seen. It stays powered while neither flag is high. It becomes unpowered when `vcc_stop_i` is seen. While unpowered, `sw_en_o` is 0 and the ramp is held at 0.
- R3: `fb_ovp_trip_i` forces `sw_en_o` to 0. Switching resumes only after `fb_ovp_rel_i` is seen, and the trip wins when both are high. This fault leaves the reference and the loop mode untouched.
- R4: `aux_ovp_trip_i` latches a fault that keeps `sw_en_o` at 0. The fault clears only at a power-up transition (unpowered to powered) during which `aux_ovp_rel_i` is high. A release at any other time has no effect.
- R5: `fb_off_i` enters a shutdown state, shown as `low_power_o`=1 with `sw_en_o`=0 and the ramp reset to 0. The state is left only when `fb_on_i` is seen.
- R6: `hot_trip_i` forces `sw_en_o` to 0 until `hot_rel_i` is seen.
- R7: While running, `ref_code_o` rises by exactly 1 every TICK_CYC cycles, from 0 to NSTEPS, and then holds at NSTEPS.
- R8: `loop_mode_o` is 0 (internal) during the ramp. It is 1 (blend) for exactly HANDOFF_CYC cycles, starting one cycle after the reference reaches NSTEPS. After that it is 2 (external) and stays there.
- R9: While `ac_absent_i` is high, `sw_en_o` is 0, `ref_code_o` is 0 and `loop_mode_o` is 0. When the flag clears, the ramp starts again from 0.
- R10: With SYNC_STAGES=2, a fault flag driven between clock edges first shows on `sw_en_o` after the third following rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vcc_start_i | input | 1 | Supply above start level |
| vcc_stop_i | input | 1 | Supply below stop level |
| fb_ovp_trip_i | input | 1 | Feedback above over-voltage trip level |
| fb_ovp_rel_i | input | 1 | Feedback below over-voltage release level |
| fb_off_i | input | 1 | Feedback below shutdown entry level |
| fb_on_i | input | 1 | Feedback above shutdown exit level |
| aux_ovp_trip_i | input | 1 | Second sense pin above its trip level |
| aux_ovp_rel_i | input | 1 | Second sense pin below its release level |
| hot_trip_i | input | 1 | Die temperature above trip level |
| hot_rel_i | input | 1 | Die temperature back below release level |
| ac_absent_i | input | 1 | Line input missing |
| sw_en_o | output | 1 | Registered switching enable |
| ref_code_o | output | REF_W | Soft-start reference code |
| loop_mode_o | output | 2 | 0 internal, 1 blend, 2 external loop |
| low_power_o | output | 1 | Shutdown state active |

## Verification
The hardest situation to reach is a latched second over-voltage that survives a power-up. To get there, the supply must be cycled once with the release flag low and then again with it high. The stimulus table does this by walking trip, a stray release, stop, a bare start, stop again, and finally start with release. Each step is held long enough to cross the synchronisers. The handoff timing also needs care. It is only reached after a full ramp, so a directed test power-cycles the block and follows every reference step and the length of the blend window, sampling at each cycle.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
   typedef enum logic [1:0] {
      LOOP_INT   = 2'd0,
      LOOP_BLEND = 2'd1,
      LOOP_EXT   = 2'd2
   } loop_mode_e;

   // positions of the flags inside the synchronised vector
   localparam int unsigned FL_ABSENT   = 0;
   localparam int unsigned FL_HOT_REL  = 1;
   localparam int unsigned FL_HOT_TRIP = 2;
   localparam int unsigned FL_AUX_REL  = 3;
   localparam int unsigned FL_AUX_TRIP = 4;
   localparam int unsigned FL_FB_ON    = 5;
   localparam int unsigned FL_FB_OFF   = 6;
   localparam int unsigned FL_OVP_REL  = 7;
   localparam int unsigned FL_OVP_TRIP = 8;
   localparam int unsigned FL_VCC_STOP = 9;
   localparam int unsigned FL_VCC_STRT = 10;
   localparam int unsigned NFLAG       = 11;

   // latch slots
   localparam int unsigned LT_PWR  = 0;
   localparam int unsigned LT_OVP  = 1;
   localparam int unsigned LT_OFF  = 2;
   localparam int unsigned LT_HOT  = 3;
   localparam int unsigned NLATCH  = 4;
endpackage

// File: rtl/pfc_flag_sync.sv
module pfc_flag_sync #(
   parameter int unsigned W      = 11,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 1) begin : g_bad
      $error("pfc_flag_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stg[s] <= '0;
         end else if (s == 0) begin
            stg[s] <= d_i;
         end else begin
            stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pfc_hyst_latch.sv
module pfc_hyst_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o,
   output logic nxt_o
);
   // set dominates a simultaneous clear
   always_comb begin
      if (set_i)      nxt_o = 1'b1;
      else if (clr_i) nxt_o = 1'b0;
      else            nxt_o = q_o;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= 1'b0;
      else         q_o <= nxt_o;
   end
endmodule

// File: rtl/pfc_softstart_ramp.sv
module pfc_softstart_ramp
   import pfc_seq_pkg::*;
#(
   parameter int unsigned REF_W       = 5,
   parameter int unsigned NSTEPS      = 16,
   parameter int unsigned TICK_CYC    = 8,
   parameter int unsigned HANDOFF_CYC = 40
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   output logic [REF_W-1:0] ref_o,
   output loop_mode_e       mode_o
);
   localparam int unsigned TW = $clog2(TICK_CYC + 1);
   localparam int unsigned HW = $clog2(HANDOFF_CYC + 1);
   localparam logic [REF_W-1:0] REF_TOP  = REF_W'(NSTEPS);
   localparam logic [TW-1:0]    TICK_END = TW'(TICK_CYC - 1);
   localparam logic [HW-1:0]    HAND_END = HW'(HANDOFF_CYC - 1);

   logic [TW-1:0] tick_q;
   logic [HW-1:0] hand_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_o  <= '0;
         tick_q <= '0;
         hand_q <= '0;
         mode_o <= LOOP_INT;
      end else if (!run_i) begin
         ref_o  <= '0;
         tick_q <= '0;
         hand_q <= '0;
         mode_o <= LOOP_INT;
      end else begin
         unique case (mode_o)
            LOOP_INT: begin
               if (ref_o == REF_TOP) begin
                  mode_o <= LOOP_BLEND;
                  hand_q <= '0;
               end else if (tick_q == TICK_END) begin
                  tick_q <= '0;
                  ref_o  <= ref_o + 1'b1;
               end else begin
                  tick_q <= tick_q + 1'b1;
               end
            end
            LOOP_BLEND: begin
               if (hand_q == HAND_END) mode_o <= LOOP_EXT;
               else                    hand_q <= hand_q + 1'b1;
            end
            default: mode_o <= LOOP_EXT;
         endcase
      end
   end
endmodule

// File: rtl/pfc_start_supervisor.sv
module pfc_start_supervisor
   import pfc_seq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REF_W       = 5,
   parameter int unsigned NSTEPS      = 16,
   parameter int unsigned TICK_CYC    = 8,
   parameter int unsigned HANDOFF_CYC = 40
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             vcc_start_i,
   input  logic             vcc_stop_i,
   input  logic             fb_ovp_trip_i,
   input  logic             fb_ovp_rel_i,
   input  logic             fb_off_i,
   input  logic             fb_on_i,
   input  logic             aux_ovp_trip_i,
   input  logic             aux_ovp_rel_i,
   input  logic             hot_trip_i,
   input  logic             hot_rel_i,
   input  logic             ac_absent_i,
   output logic             sw_en_o,
   output logic [REF_W-1:0] ref_code_o,
   output logic [1:0]       loop_mode_o,
   output logic             low_power_o
);
   if (NSTEPS >= (1 << REF_W)) begin : g_bad_steps
      $error("pfc_start_supervisor: NSTEPS does not fit REF_W");
   end
   if (NSTEPS < 1 || TICK_CYC < 1 || HANDOFF_CYC < 1) begin : g_bad_cnt
      $error("pfc_start_supervisor: counts must be non-zero");
   end

   logic [NFLAG-1:0] raw_flags, syn;

   assign raw_flags = {vcc_start_i, vcc_stop_i, fb_ovp_trip_i, fb_ovp_rel_i,
                       fb_off_i, fb_on_i, aux_ovp_trip_i, aux_ovp_rel_i,
                       hot_trip_i, hot_rel_i, ac_absent_i};

   pfc_flag_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_flags),
      .q_o    (syn)
   );

   // self-clearing hysteresis states
   logic [NLATCH-1:0] lat_set, lat_clr, lat_q, lat_nxt;

   assign lat_set[LT_PWR] = syn[FL_VCC_STRT];
   assign lat_clr[LT_PWR] = syn[FL_VCC_STOP];
   assign lat_set[LT_OVP] = syn[FL_OVP_TRIP];
   assign lat_clr[LT_OVP] = syn[FL_OVP_REL];
   assign lat_set[LT_OFF] = syn[FL_FB_OFF];
   assign lat_clr[LT_OFF] = syn[FL_FB_ON];
   assign lat_set[LT_HOT] = syn[FL_HOT_TRIP];
   assign lat_clr[LT_HOT] = syn[FL_HOT_REL];

   for (genvar i = 0; i < NLATCH; i++) begin : g_latch
      pfc_hyst_latch u_lat (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (lat_set[i]),
         .clr_i  (lat_clr[i]),
         .q_o    (lat_q[i]),
         .nxt_o  (lat_nxt[i])
      );
   end

   // second over-voltage: cleared only by a power-up edge with the pin released
   logic aux_lock_q, aux_lock_nxt, pwr_up_edge;
   assign pwr_up_edge = !lat_q[LT_PWR] && lat_nxt[LT_PWR];

   always_comb begin
      if (syn[FL_AUX_TRIP])                     aux_lock_nxt = 1'b1;
      else if (pwr_up_edge && syn[FL_AUX_REL])  aux_lock_nxt = 1'b0;
      else                                      aux_lock_nxt = aux_lock_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) aux_lock_q <= 1'b0;
      else         aux_lock_q <= aux_lock_nxt;
   end

   // enable uses next-state values so a fault drops it in the cycle it is seen
   logic sw_en_d;
   assign sw_en_d = lat_nxt[LT_PWR] && !lat_nxt[LT_OVP] && !lat_nxt[LT_OFF] &&
                    !lat_nxt[LT_HOT] && !aux_lock_nxt && !syn[FL_ABSENT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sw_en_o <= 1'b0;
      else         sw_en_o <= sw_en_d;
   end

   logic       ramp_run;
   loop_mode_e ramp_mode;
   assign ramp_run = lat_q[LT_PWR] && !lat_q[LT_OFF] && !syn[FL_ABSENT];

   pfc_softstart_ramp #(
      .REF_W       (REF_W),
      .NSTEPS      (NSTEPS),
      .TICK_CYC    (TICK_CYC),
      .HANDOFF_CYC (HANDOFF_CYC)
   ) u_ramp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (ramp_run),
      .ref_o  (ref_code_o),
      .mode_o (ramp_mode)
   );

   assign loop_mode_o = ramp_mode;
   assign low_power_o = lat_q[LT_OFF];
endmodule

// File: rtl/pfc_start_supervisor_chk.sv
module pfc_start_supervisor_chk #(
   parameter int unsigned REF_W  = 5,
   parameter int unsigned NSTEPS = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [10:0]      syn,
   input logic             pwr_q,
   input logic             aux_lock_q,
   input logic             sw_en_o,
   input logic             low_power_o,
   input logic [REF_W-1:0] ref_code_o,
   input logic [1:0]       loop_mode_o
);
   // R2: unpowered with no start flag keeps switching off
   assert_no_switch_unpowered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pwr_q && !syn[10]) |=> !sw_en_o);

   // R10 (R3, R6): a synchronised trip drops the enable at the next edge
   assert_fault_drops_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (syn[8] || syn[2] || syn[4] || syn[6]) |=> !sw_en_o);

   // R4: latched second over-voltage blocks switching
   assert_aux_lock_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      aux_lock_q |-> !sw_en_o);

   // R5: shutdown state never switches
   assert_low_power_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_power_o |-> !sw_en_o);

   // R7: reference moves only by one step upward or back to zero
   assert_ref_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_code_o != $past(ref_code_o)) |->
         (ref_code_o == $past(ref_code_o) + 1'b1 || ref_code_o == '0));

   assert_ref_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_code_o <= REF_W'(NSTEPS));

   // R8: loop leaves internal control only at the top of the ramp
   assert_mode_at_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loop_mode_o != 2'd0) |-> (ref_code_o == REF_W'(NSTEPS)));

   // R9: missing line forces the ramp back to zero
   assert_absent_resets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      syn[0] |=> (ref_code_o == '0 && loop_mode_o == 2'd0));
endmodule

bind pfc_start_supervisor pfc_start_supervisor_chk #(
   .REF_W  (REF_W),
   .NSTEPS (NSTEPS)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .syn         (syn),
   .pwr_q       (lat_q[0]),
   .aux_lock_q  (aux_lock_q),
   .sw_en_o     (sw_en_o),
   .low_power_o (low_power_o),
   .ref_code_o  (ref_code_o),
   .loop_mode_o (loop_mode_o)
);

// File: tb/test_pfc_start_supervisor.sv
module test_pfc_start_supervisor;
   localparam int REF_W = 5;
   localparam int NSTEPS = 16;
   localparam int TICK_CYC = 8;
   localparam int HANDOFF_CYC = 40;
   localparam int NVEC = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   // stim bits: 10 start,9 stop,8 ovp trip,7 ovp rel,6 off,5 on,4 aux trip,3 aux rel,2 hot trip,1 hot rel,0 absent
   logic [10:0] stim = '0;
   logic sw_en, low_power;
   logic [REF_W-1:0] ref_code;
   logic [1:0] loop_mode;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pfc_start_supervisor #(
      .SYNC_STAGES(2), .REF_W(REF_W), .NSTEPS(NSTEPS),
      .TICK_CYC(TICK_CYC), .HANDOFF_CYC(HANDOFF_CYC)
   ) i_pfc_start_supervisor (
      .clk_i(clk), .rst_ni(rst_n),
      .vcc_start_i(stim[10]), .vcc_stop_i(stim[9]),
      .fb_ovp_trip_i(stim[8]), .fb_ovp_rel_i(stim[7]),
      .fb_off_i(stim[6]), .fb_on_i(stim[5]),
      .aux_ovp_trip_i(stim[4]), .aux_ovp_rel_i(stim[3]),
      .hot_trip_i(stim[2]), .hot_rel_i(stim[1]),
      .ac_absent_i(stim[0]),
      .sw_en_o(sw_en), .ref_code_o(ref_code),
      .loop_mode_o(loop_mode), .low_power_o(low_power)
   );

   // {flags[10:0], expected sw_en, expected low_power}
   localparam logic [12:0] VEC [NVEC] = '{
      13'b00000000000_00, // R2 no supply
      13'b10000000000_10, // R2 start
      13'b00000000000_10, // R2 hysteresis hold
      13'b00100000000_00, // R3 trip
      13'b00000000000_00, // R3 held off
      13'b00010000000_10, // R3 release
      13'b00000000100_00, // R6 trip
      13'b00000000000_00, // R6 held
      13'b00000000010_10, // R6 release
      13'b00001000000_01, // R5 enter shutdown
      13'b00000000000_01, // R5 held
      13'b00000100000_10, // R5 leave
      13'b00000010000_00, // R4 trip
      13'b00000001000_00, // R4 release ignored
      13'b01000000000_00, // R4 supply down
      13'b10000000000_00, // R4 up without release
      13'b01000000000_00, // R4 down again
      13'b10000001000_10, // R4 up with release
      13'b00000000001_00, // R9 absent
      13'b00000000000_10, // R9 returned
      13'b01000000000_00, // R2 stop
      13'b10000000000_10  // R2 restart
   };
   localparam int VREQ [NVEC] = '{2,2,2,3,3,3,6,6,6,5,5,5,4,4,4,4,4,4,9,9,2,2};

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic apply(input logic [10:0] v, input int n);
      stim = v;
      cyc(n);
      stim = '0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int last_chg, prev_ref, blend_len, cnt;
      cyc(3);
      // R1 reset state
      chk("R1 sw_en", int'(sw_en), 0);
      chk("R1 ref", int'(ref_code), 0);
      chk("R1 mode", int'(loop_mode), 0);
      chk("R1 low_power", int'(low_power), 0);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 sw_en after release", int'(sw_en), 0);

      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][12:2], 6);
         cyc(1);
         chk($sformatf("R%0d vec%0d sw_en", VREQ[i], i), int'(sw_en), int'(VEC[i][1]));
         chk($sformatf("R%0d vec%0d low_power", VREQ[i], i), int'(low_power), int'(VEC[i][0]));
      end

      // R10 latency: running, hot trip appears after the third edge
      stim = 11'b00000000100;
      cyc(1); chk("R10 edge1", int'(sw_en), 1);
      cyc(1); chk("R10 edge2", int'(sw_en), 1);
      cyc(1); chk("R10 edge3", int'(sw_en), 0);
      apply(11'b00000000010, 6);
      cyc(1);
      chk("R6 release after R10", int'(sw_en), 1);

      // R3 trip wins over simultaneous release
      apply(11'b00110000000, 6);
      chk("R3 set priority", int'(sw_en), 0);
      apply(11'b00010000000, 6);
      chk("R3 release", int'(sw_en), 1);

      // R7 / R8 full ramp from a fresh power-up
      apply(11'b01000000000, 6);
      chk("R2 ramp held at zero", int'(ref_code), 0);
      chk("R7 mode internal when off", int'(loop_mode), 0);
      stim = 11'b10000000000;
      cyc(1);
      stim = '0;
      last_chg = -1;
      prev_ref = int'(ref_code);
      cnt = 0;
      while (int'(ref_code) != NSTEPS && cnt < 2000) begin
         cyc(1);
         cnt++;
         if (int'(ref_code) != prev_ref) begin
            chk("R7 step size", int'(ref_code), prev_ref + 1);
            if (last_chg >= 0) chk("R7 step interval", cnt - last_chg, TICK_CYC);
            last_chg = cnt;
            prev_ref = int'(ref_code);
         end
      end
      chk("R7 reached top", int'(ref_code), NSTEPS);
      chk("R8 internal at top", int'(loop_mode), 0);
      blend_len = 0;
      cyc(1);
      chk("R8 blend next cycle", int'(loop_mode), 1);
      while (loop_mode == 2'd1 && blend_len < 1000) begin
         blend_len++;
         cyc(1);
      end
      chk("R8 blend length", blend_len, HANDOFF_CYC);
      chk("R8 external", int'(loop_mode), 2);
      cyc(50);
      chk("R7 hold top", int'(ref_code), NSTEPS);
      chk("R8 stays external", int'(loop_mode), 2);

      // R3 primary trip leaves reference and mode alone
      apply(11'b00100000000, 6);
      chk("R3 sw_en off", int'(sw_en), 0);
      chk("R3 ref kept", int'(ref_code), NSTEPS);
      chk("R3 mode kept", int'(loop_mode), 2);
      apply(11'b00010000000, 6);

      // R9 absent resets and then ramp restarts
      stim = 11'b00000000001;
      cyc(6);
      chk("R9 ref zero", int'(ref_code), 0);
      chk("R9 mode internal", int'(loop_mode), 0);
      chk("R9 sw_en off", int'(sw_en), 0);
      stim = '0;
      cyc(3 * TICK_CYC + 10);
      chk("R9 ramp restarted", int'(ref_code > 0 && ref_code < NSTEPS), 1);

      // R5 shutdown resets the ramp
      apply(11'b00001000000, 6);
      chk("R5 ref zero", int'(ref_code), 0);
      chk("R5 low_power", int'(low_power), 1);
      apply(11'b00000100000, 6);
      chk("R5 left", int'(low_power), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule